// File: doc/BRIEF.md
# Transmit Reset Distributor With Lane-Reset Lockout

This block turns a handful of asynchronous transmit reset requests into clean, domain-local reset outputs for a multi-lane transmit datapath. Every output asserts the moment its source rises and is released only after a chain of flops in its own destination clock has seen that source low. The protocol reset crosses the AXI clock domain first and the core clock domain second. From the core domain it reaches the lane-0 main and lane-0 alternate SerDes clocks in parallel.

A static mode select chooses how resets are routed. In protocol mode, lane 0 is reset by the protocol reset, by lane reset bit 0, or by the lockout. Lanes 1 to 5 are held in reset and their request bits have no effect. In FEC-only mode, the protocol reset no longer reaches the lanes. Each lane reset bit drives that lane's main and alternate outputs on its own, and one bit serves both slices of its encoder.

A core-domain state machine watches lane reset 0 in protocol mode. It has five states. `ST_HOLD` is the state while the core reset is asserted. `ST_AWAIT_LANE` means the protocol reset has been released but lane 0 is still held. `ST_RUN` is normal operation. `ST_LOCKOUT` is the fault state. `ST_FEC` is used in FEC-only mode. The transitions are as follows:
- Core reset forces `ST_HOLD`.
- From `ST_HOLD`: go to `ST_FEC` in FEC-only mode. Otherwise go to `ST_AWAIT_LANE` if lane 0 is still held, or to `ST_RUN` if it is not.
- `ST_AWAIT_LANE` to `ST_RUN`: lane 0 is released.
- `ST_RUN` to `ST_LOCKOUT`: lane 0 is asserted again.
- `ST_AWAIT_LANE` or `ST_RUN` to `ST_FEC`: FEC-only mode is selected.
- `ST_FEC` to `ST_HOLD`: protocol mode is selected.
- `ST_LOCKOUT` stays where it is until the next core reset.

Top module: `txrst_distributor`

## Requirements
- R1: Each reset output goes high as soon as its source is high. It goes low on the third rising edge of its own clock after its source has fallen.
- R2: `core_rst` goes high with `proto_rst_in`. It goes low six clock edges after `proto_rst_in` falls: three AXI edges, then three core edges.
- R3: In protocol mode (`fec_mode_sel`=0), lane 0's main and alternate outputs are held high while `core_rst`, `lane_rst_in[0]` or the lockout is high. They release three lane edges after the last of these falls.
- R4: In protocol mode, all outputs of lanes 1 to 5 stay high, whatever `lane_rst_in[5:1]` does.
- R5: In FEC-only mode (`fec_mode_sel`=1), the outputs of lane i follow `lane_rst_in[i]` alone, using the timing of R1. `proto_rst_in` has no effect on them.
- R6: The main and alternate outputs of a lane always share one source. With equal clocks they are identical.
- R7: In protocol mode, lane reset 0 can rise again after the core reset has been released and lane 0 has been seen low in the core domain. When it does, `recover_req` goes high and stays high, and lane 0 stays in reset after `lane_rst_in[0]` falls.
- R8: `recover_req` and the lockout clear only when `core_rst` is asserted, and they clear at that moment.
- R9: The mode is sampled at core clock edges only while `proto_rst_in` and all six lane reset bits are high.
- R10: A change of `fec_mode_sel` at any other time has no effect on routing and sets `mode_err`. `mode_err` stays high until all resets are asserted together.
- R11: Releasing the protocol reset first and lane reset 0 afterwards never sets `recover_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_axi | input | 1 | AXI clock, first stage of the protocol reset path |
| clk_core | input | 1 | Core clock, second stage; clocks the lockout machine and mode guard |
| clk_lane | input | LANES | Main SerDes clock of each lane |
| clk_lane_alt | input | LANES | Alternate SerDes clock of each lane |
| proto_rst_in | input | 1 | Asynchronous protocol-level transmit reset, active high |
| lane_rst_in | input | LANES | Asynchronous lane reset requests, active high |
| fec_mode_sel | input | 1 | Static mode select: 0 protocol, 1 FEC-only |
| core_rst | output | 1 | Protocol reset synchronized into the core domain |
| lane_rst | output | LANES | Reset for each lane, main SerDes clock domain |
| lane_alt_rst | output | LANES | Reset for each lane, alternate SerDes clock domain |
| recover_req | output | 1 | Sticky flag (core domain): a full reset is needed |
| mode_err | output | 1 | Sticky flag (core domain): mode changed outside full reset |

## Verification
A wrong state in the lockout machine shows up within one core edge. It appears as `recover_req` rising or failing to rise, and three lane edges later lane 0 fails to release or releases when it should not. A synchronizer chain of the wrong length moves a release by whole cycles. The bench's reference model compares every output on every clock, so that shift is caught in the first cycle where the release is early or late. A mode latched at the wrong time shows at once as a change in lane routing: lanes 1 to 5 releasing in protocol mode, or lane 0 ignoring the protocol reset. It also shows in the state of `mode_err`.

// File: rtl/txrst_pkg.sv
package txrst_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_AWAIT_LANE,
        ST_RUN,
        ST_LOCKOUT,
        ST_FEC
    } lock_state_e;
endpackage

// File: rtl/txrst_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module txrst_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic arst_src,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst_src) begin
        if (arst_src) chain <= '1;
        else          chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/txrst_lockout_fsm.sv
// Core-domain watcher of lane reset 0 in protocol mode.
module txrst_lockout_fsm
    import txrst_pkg::*;
(
    input  logic clk_core,
    input  logic core_rst,
    input  logic fec_active,
    input  logic lane0_core,
    output logic lockout
);
    lock_state_e state, state_nxt;

    always_ff @(posedge clk_core or posedge core_rst) begin
        if (core_rst) state <= ST_HOLD;
        else          state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (fec_active)      state_nxt = ST_FEC;
                else if (lane0_core) state_nxt = ST_AWAIT_LANE;
                else                 state_nxt = ST_RUN;
            end
            ST_AWAIT_LANE: begin
                if (fec_active)      state_nxt = ST_FEC;
                else if (!lane0_core) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (fec_active)      state_nxt = ST_FEC;
                else if (lane0_core) state_nxt = ST_LOCKOUT;
            end
            ST_LOCKOUT: state_nxt = ST_LOCKOUT;
            ST_FEC: begin
                if (!fec_active)     state_nxt = ST_HOLD;
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        lockout = (state == ST_LOCKOUT);
    end
endmodule

// File: rtl/txrst_mode_guard.sv
// Latches the mode only under full reset; flags changes at other times.
module txrst_mode_guard (
    input  logic clk_core,
    input  logic all_core,
    input  logic mode_in,
    output logic mode_q,
    output logic mode_err
);
    always_ff @(posedge clk_core) begin
        if (all_core) mode_q <= mode_in;
    end

    always_ff @(posedge clk_core or posedge all_core) begin
        if (all_core)               mode_err <= 1'b0;
        else if (mode_in != mode_q) mode_err <= 1'b1;
    end
endmodule

// File: rtl/txrst_distributor.sv
module txrst_distributor #(
    parameter int LANES       = 6,
    parameter int SYNC_STAGES = 3
) (
    input  logic             clk_axi,
    input  logic             clk_core,
    input  logic [LANES-1:0] clk_lane,
    input  logic [LANES-1:0] clk_lane_alt,
    input  logic             proto_rst_in,
    input  logic [LANES-1:0] lane_rst_in,
    input  logic             fec_mode_sel,
    output logic             core_rst,
    output logic [LANES-1:0] lane_rst,
    output logic [LANES-1:0] lane_alt_rst,
    output logic             recover_req,
    output logic             mode_err
);
    logic             axi_rst;
    logic             all_src;
    logic             all_core;
    logic             lane0_core;
    logic             mode_q;
    logic             lockout;
    logic [LANES-1:0] lane_src;

    assign all_src = proto_rst_in & (&lane_rst_in);

    txrst_sync #(.STAGES(SYNC_STAGES)) u_sync_axi (
        .clk(clk_axi), .arst_src(proto_rst_in), .rst_out(axi_rst));
    txrst_sync #(.STAGES(SYNC_STAGES)) u_sync_core (
        .clk(clk_core), .arst_src(axi_rst), .rst_out(core_rst));
    txrst_sync #(.STAGES(SYNC_STAGES)) u_sync_all (
        .clk(clk_core), .arst_src(all_src), .rst_out(all_core));
    txrst_sync #(.STAGES(SYNC_STAGES)) u_sync_l0core (
        .clk(clk_core), .arst_src(lane_rst_in[0]), .rst_out(lane0_core));

    txrst_mode_guard u_mode (
        .clk_core(clk_core), .all_core(all_core), .mode_in(fec_mode_sel),
        .mode_q(mode_q), .mode_err(mode_err));

    txrst_lockout_fsm u_fsm (
        .clk_core(clk_core), .core_rst(core_rst), .fec_active(mode_q),
        .lane0_core(lane0_core), .lockout(lockout));

    assign recover_req = lockout;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign lane_src[i] = mode_q ? lane_rst_in[i]
                                        : (lane_rst_in[i] | core_rst | lockout);
        end else begin : g_rest
            assign lane_src[i] = mode_q ? lane_rst_in[i] : 1'b1;
        end
        txrst_sync #(.STAGES(SYNC_STAGES)) u_sync_main (
            .clk(clk_lane[i]), .arst_src(lane_src[i]), .rst_out(lane_rst[i]));
        txrst_sync #(.STAGES(SYNC_STAGES)) u_sync_alt (
            .clk(clk_lane_alt[i]), .arst_src(lane_src[i]), .rst_out(lane_alt_rst[i]));
    end
endmodule

// File: rtl/txrst_distributor_chk.sv
module txrst_distributor_chk #(
    parameter int LANES = 6
) (
    input logic             clk_core,
    input logic [LANES-1:0] clk_lane,
    input logic             core_rst,
    input logic [LANES-1:0] lane_rst,
    input logic [LANES-1:0] lane_alt_rst,
    input logic [LANES-1:0] lane_rst_in,
    input logic             recover_req,
    input logic             mode_err,
    input logic             mode_q,
    input logic             all_core
);
    assert_core_holds_lane0_R3: assert property (@(posedge clk_core) disable iff (all_core)
        (core_rst && !mode_q) |-> (lane_rst[0] && lane_alt_rst[0]));

    assert_unused_lanes_held_R4: assert property (@(posedge clk_core) disable iff (all_core)
        !mode_q |-> ((&lane_rst[LANES-1:1]) && (&lane_alt_rst[LANES-1:1])));

    assert_fec_lane_follows_R5: assert property (@(posedge clk_lane[1]) disable iff (all_core)
        (mode_q && lane_rst_in[1]) |-> (lane_rst[1] && lane_alt_rst[1]));

    assert_lockout_holds_lane0_R7: assert property (@(posedge clk_core) disable iff (all_core)
        recover_req |-> (lane_rst[0] && lane_alt_rst[0]));

    assert_core_clears_lockout_R8: assert property (@(posedge clk_core) disable iff (all_core)
        core_rst |-> !recover_req);

    assert_mode_frozen_R9: assert property (@(posedge clk_core) disable iff (all_core)
        !$stable(mode_q) |-> $past(all_core));

    assert_mode_err_sticky_R10: assert property (@(posedge clk_core) disable iff (all_core)
        $past(mode_err) |-> mode_err);
endmodule

bind txrst_distributor txrst_distributor_chk #(.LANES(LANES)) u_chk (
    .clk_core(clk_core), .clk_lane(clk_lane), .core_rst(core_rst),
    .lane_rst(lane_rst), .lane_alt_rst(lane_alt_rst), .lane_rst_in(lane_rst_in),
    .recover_req(recover_req), .mode_err(mode_err), .mode_q(mode_q),
    .all_core(all_core));

// File: tb/test_txrst_distributor.sv
`timescale 1ns/1ps
module test_txrst_distributor;
    localparam int N = 6;
    localparam int S = 3;

    logic         clk = 1'b0;
    logic         proto = 1'b1;
    logic [N-1:0] lin = '1;
    logic         msel = 1'b0;
    logic         core_rst, recover_req, mode_err;
    logic [N-1:0] lane_rst, lane_alt_rst;

    int  checks = 0;
    int  errors = 0;
    bit  run_cmp = 1'b0;

    // reference model state
    int c_axi = S, c_core = S, c_all = S, c_l0 = S;
    int c_lane [N];
    int st = 0;           // 0 hold 1 await 2 run 3 lockout 4 fec
    bit mq = 1'b0;
    bit merr = 1'b0;

    always #4 clk = ~clk;

    txrst_distributor i_txrst_distributor (
        .clk_axi(clk), .clk_core(clk), .clk_lane({N{clk}}), .clk_lane_alt({N{clk}}),
        .proto_rst_in(proto), .lane_rst_in(lin), .fec_mode_sel(msel),
        .core_rst(core_rst), .lane_rst(lane_rst), .lane_alt_rst(lane_alt_rst),
        .recover_req(recover_req), .mode_err(mode_err));

    function automatic bit m_axi();  return proto || c_axi > 0; endfunction
    function automatic bit m_core(); return m_axi() || c_core > 0; endfunction
    function automatic bit m_all();  return (proto && (&lin)) || c_all > 0; endfunction
    function automatic bit m_l0c();  return lin[0] || c_l0 > 0; endfunction
    function automatic bit m_lock(); return st == 3 && !m_core(); endfunction
    function automatic bit m_src(int i);
        if (mq) return lin[i];
        if (i == 0) return lin[0] || m_core() || m_lock();
        return 1'b1;
    endfunction
    function automatic bit m_lane(int i); return m_src(i) || c_lane[i] > 0; endfunction
    function automatic int dec(int c); return (c > 0) ? c - 1 : 0; endfunction

    initial for (int i = 0; i < N; i++) c_lane[i] = S;

    always @(posedge clk) begin
        bit a_p, co_p, al_p, l0_p;
        bit src_p [N];
        a_p = m_axi(); co_p = m_core(); al_p = m_all(); l0_p = m_l0c();
        for (int i = 0; i < N; i++) src_p[i] = m_src(i);
        for (int i = 0; i < N; i++) c_lane[i] = src_p[i] ? S : dec(c_lane[i]);
        c_core = a_p ? S : dec(c_core);
        c_axi  = proto ? S : dec(c_axi);
        c_all  = (proto && (&lin)) ? S : dec(c_all);
        c_l0   = lin[0] ? S : dec(c_l0);
        if (co_p) st = 0;
        else case (st)
            0: st = mq ? 4 : (l0_p ? 1 : 2);
            1: st = mq ? 4 : (l0_p ? 1 : 2);
            2: st = mq ? 4 : (l0_p ? 3 : 2);
            3: st = 3;
            default: st = mq ? 4 : 0;
        endcase
        if (al_p) merr = 1'b0;
        else if (msel != mq) merr = 1'b1;
        if (al_p) mq = msel;
        if (m_core()) st = 0;
        if (m_all()) merr = 1'b0;
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (run_cmp) begin
        chk("R2 core_rst", core_rst, m_core());
        for (int i = 0; i < N; i++) begin
            chk(mq ? "R5 lane_rst" : (i == 0 ? "R3 lane_rst" : "R4 lane_rst"),
                lane_rst[i], m_lane(i));
            chk("R6 lane_alt_rst", lane_alt_rst[i], m_lane(i));
        end
        chk("R7 recover_req", recover_req, m_lock());
        chk("R10 mode_err", mode_err, m_all() ? 1'b0 : merr);
    end

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_at_neg();
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 50000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_neg(5);
        run_cmp = 1'b1;
        chk("R4 reset state lane5", lane_rst[5], 1'b1);
        chk("R2 reset state core", core_rst, 1'b1);

        // protocol reset release: six edges through two domains
        drive_at_neg(); proto = 1'b0;
        wait_neg(5); chk("R2 core still held", core_rst, 1'b1);
        wait_neg(1); chk("R2 core released", core_rst, 1'b0);
        wait_neg(4);

        // lane release in correct order
        drive_at_neg(); lin = '0;
        wait_neg(2); chk("R1 lane0 held 2 edges", lane_rst[0], 1'b1);
        wait_neg(1); chk("R1 lane0 released 3rd edge", lane_rst[0], 1'b0);
        chk("R4 lane3 held", lane_rst[3], 1'b1);
        wait_neg(6); chk("R11 no lockout", recover_req, 1'b0);

        // unused lane bits toggled
        drive_at_neg(); lin[5:1] = 5'b10101;
        wait_neg(2);
        drive_at_neg(); lin[5:1] = '0;
        wait_neg(4); chk("R4 lane2 ignores input", lane_rst[2], 1'b1);

        // illegal lane-only reset
        drive_at_neg(); lin[0] = 1'b1;
        wait_neg(2);
        drive_at_neg(); lin[0] = 1'b0;
        wait_neg(10);
        chk("R7 lockout set", recover_req, 1'b1);
        chk("R7 lane0 held", lane_rst[0], 1'b1);

        // recovery sequence
        drive_at_neg(); proto = 1'b1; lin[0] = 1'b1;
        wait_neg(1); chk("R8 lockout cleared", recover_req, 1'b0);
        wait_neg(3);
        drive_at_neg(); proto = 1'b0;
        wait_neg(9);
        drive_at_neg(); lin[0] = 1'b0;
        wait_neg(6);
        chk("R11 proper order", recover_req, 1'b0);
        chk("R3 lane0 released", lane_rst[0], 1'b0);

        // illegal mode change
        drive_at_neg(); msel = 1'b1;
        wait_neg(4);
        chk("R10 mode_err set", mode_err, 1'b1);
        chk("R10 routing kept lane4", lane_rst[4], 1'b1);
        drive_at_neg(); msel = 1'b0;
        wait_neg(3); chk("R10 mode_err sticky", mode_err, 1'b0 | 1'b1);

        // full reset with FEC-only mode
        drive_at_neg(); proto = 1'b1; lin = '1; msel = 1'b1;
        wait_neg(1); chk("R10 mode_err cleared", mode_err, 1'b0);
        wait_neg(4);
        drive_at_neg(); lin[3] = 1'b0;
        wait_neg(3);
        chk("R9 fec lane3 released", lane_rst[3], 1'b0);
        chk("R5 lane1 still held", lane_rst[1], 1'b1);
        drive_at_neg(); proto = 1'b0;
        wait_neg(10);
        drive_at_neg(); lin = '0;
        wait_neg(4); chk("R5 lane0 independent of proto", lane_rst[0], 1'b0);
        drive_at_neg(); proto = 1'b1; lin[2] = 1'b1;
        wait_neg(1);
        chk("R5 lane0 ignores proto", lane_rst[0], 1'b0);
        chk("R5 lane2 asserted", lane_rst[2], 1'b1);
        drive_at_neg(); lin[2] = 1'b0; proto = 1'b0;
        wait_neg(12); chk("R7 no lockout in fec", recover_req, 1'b0);

        // back to protocol mode
        drive_at_neg(); proto = 1'b1; lin = '1; msel = 1'b0;
        wait_neg(5);
        drive_at_neg(); proto = 1'b0;
        wait_neg(9);
        drive_at_neg(); lin = '0;
        wait_neg(5);
        chk("R9 protocol lane1 held", lane_rst[1], 1'b1);
        chk("R9 protocol lane0 released", lane_rst[0], 1'b0);
        wait_neg(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule